// File: doc/BRIEF.md
# Branch Resolution Unit with Loop Counter

This block resolves branches for a simple in-order RISC front end. Each cycle it may accept one decoded branch. A branch carries its own address, a signed word displacement, a condition-bit selector with a sense, a static predict hint, and flags for counter use, link capture and target-from-link. The unit keeps three private registers: a link register, a loop count register and a 32-bit condition register. It computes targets with its own adder and never touches the general-purpose register file.

Branches that need no condition bit, or whose condition bit is already settled, resolve in the cycle they are presented. In that case the redirect to fetch is driven combinationally, so no bubble is added. A counter-form branch decrements the count register and requires the decremented value to be nonzero, all within the same instruction. If the selected condition field is still claimed by an in-flight integer result, the unit follows the hint bit and asserts a hold output. The hold tells fetch to keep the other path's instructions. When the integer unit writes the awaited field, a wrong guess raises a one-cycle mispredict pulse that carries the correct address.

Top module: `brunit_top`

## Requirements
- R1: After reset the link, count and condition registers are zero. `br_ready` is 1, and `alt_hold`, `mispred` and `redir_valid` are 0.
- R2: The relative target is `br_pc + sign_extend(br_disp)*4`. When `br_to_link` is set, the target is the link register value instead. A branch that resolves taken drives `redir_valid`=1 and `redir_addr`=target in the same cycle it is presented.
- R3: `br_bit` selects condition-register bit `cr_q[br_bit]`. Field f occupies bits `4f+3..4f`, so `br_bit[4:2]` is the field and `br_bit[1:0]` the bit inside it. With `br_use_cond` set, the condition holds when that bit equals `br_sense`.
- R4: With `br_use_ctr` set, an accepted branch decrements the count register and is taken only if the decremented value is nonzero. When the condition is also used, the branch is taken only if both tests pass.
- R5: An accepted branch with `br_link` set loads the link register with `br_pc+4`. A link-target branch uses the link value from before this update.
- R6: A branch presented with `br_kill`=1 produces no redirect and changes neither the link nor the count register.
- R7: `ctr_ld_en` loads `ctr_ld_val` into the count register. The load takes priority over a same-cycle decrement.
- R8: `cr_wr_en` writes `cr_wr_data` into field `cr_wr_fld`. `cr_claim_en` marks a field pending, and a later write clears the mark. A write in the same cycle as a branch is forwarded to that branch, which then resolves at once.
- R9: A conditional branch on a pending field is predicted taken when `br_hint`=1 and the counter test passes. It redirects if predicted taken. From the next cycle `br_ready`=0 and `alt_hold`=1 until the field is written. Branches presented while `br_ready`=0 have no effect.
- R10: In the cycle after the awaited field is written, `alt_hold` is 0. If the real outcome differs from the prediction, `mispred`=1 and `mispred_addr` is the real path: the target if taken, `br_pc+4` if not. If the outcome matches, `mispred` stays 0.
- R11: `mispred` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Branch presented |
| br_kill | input | 1 | Cancel the presented branch |
| br_pc | input | 32 | Address of the branch |
| br_disp | input | 24 | Signed word displacement |
| br_to_link | input | 1 | Take target from link register |
| br_use_cond | input | 1 | Branch tests a condition bit |
| br_bit | input | 5 | Condition bit index |
| br_sense | input | 1 | Required value of the condition bit |
| br_use_ctr | input | 1 | Decrement counter, require nonzero |
| br_link | input | 1 | Save return address in link register |
| br_hint | input | 1 | Static prediction: 1 = taken |
| ctr_ld_en | input | 1 | Load count register |
| ctr_ld_val | input | 32 | Count load value |
| cr_claim_en | input | 1 | Mark a condition field pending |
| cr_claim_fld | input | 3 | Field to mark |
| cr_wr_en | input | 1 | Condition field write |
| cr_wr_fld | input | 3 | Field written |
| cr_wr_data | input | 4 | Field data |
| br_ready | output | 1 | Unit can accept a branch |
| redir_valid | output | 1 | Fetch redirect this cycle |
| redir_addr | output | 32 | Redirect address |
| alt_hold | output | 1 | Keep the other path's buffered instructions |
| mispred | output | 1 | Mispredict pulse |
| mispred_addr | output | 32 | Correct address on mispredict |
| lr_q | output | 32 | Link register |
| ctr_q | output | 32 | Count register |
| cr_q | output | 32 | Condition register |

## Verification
The resolve path is driven with positive and negative displacements and with link-target branches. These separate adder and sign-extension faults from target-select faults. Counter branches step a loaded count down to one, so the single not-taken exit and the decrement are both observed. Condition cases flip the sense and move to a neighbouring bit to expose bit-select errors. Pending-field branches are run with correct and wrong hints in each direction, which tells apart the recovery address, the pulse length and the release of the hold.

// File: rtl/brunit_pkg.sv
package brunit_pkg;
   localparam int unsigned FLD_W   = 4;
   localparam int unsigned INSN_SZ = 4;

   // where a pending branch goes once resolved
   typedef struct packed {
      logic pred_tkn;
      logic ctr_ok;
      logic sense;
   } pend_flags_t;
endpackage

// File: rtl/brunit_tgt.sv
module brunit_tgt #(
   parameter int unsigned AW     = 32,
   parameter int unsigned DISP_W = 24
) (
   input  logic [AW-1:0]     pc,
   input  logic [DISP_W-1:0] disp,
   output logic [AW-1:0]     rel_tgt,
   output logic [AW-1:0]     ret_addr
);
   localparam int unsigned EXT_W = AW - DISP_W - 2;

   logic [AW-1:0] off;

   if (AW < DISP_W + 2) begin : g_bad_width
      $error("brunit_tgt: AW must be at least DISP_W+2");
   end else if (EXT_W == 0) begin : g_noext
      assign off = {disp, 2'b00};
   end else begin : g_ext
      assign off = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
   end

   assign rel_tgt  = pc + off;
   assign ret_addr = pc + AW'(brunit_pkg::INSN_SZ);
endmodule

// File: rtl/brunit_ctr.sv
module brunit_ctr #(
   parameter int unsigned CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_en,
   input  logic [CW-1:0] ld_val,
   input  logic          dec_en,
   output logic [CW-1:0] ctr_q,
   output logic          dec_nz
);
   if (CW < 2) begin : g_bad_cw
      $error("brunit_ctr: CW must be at least 2");
   end

   logic [CW-1:0] ctr_m1;
   assign ctr_m1 = ctr_q - CW'(1);
   assign dec_nz = (ctr_m1 != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)      ctr_q <= '0;
      else if (ld_en)  ctr_q <= ld_val;
      else if (dec_en) ctr_q <= ctr_m1;
   end

   // R4
   ctr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_en && !ld_en) |=> (ctr_q == $past(ctr_q) - CW'(1)));
   // R7
   ctr_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> (ctr_q == $past(ld_val)));
endmodule

// File: rtl/brunit_cr.sv
module brunit_cr #(
   parameter int unsigned NFLD = 8,
   localparam int unsigned FW    = brunit_pkg::FLD_W,
   localparam int unsigned CRW   = NFLD * FW,
   localparam int unsigned FSEL  = $clog2(NFLD),
   localparam int unsigned IDX_W = $clog2(CRW)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             claim_en,
   input  logic [FSEL-1:0]  claim_fld,
   input  logic             wr_en,
   input  logic [FSEL-1:0]  wr_fld,
   input  logic [FW-1:0]    wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_bit,
   output logic             rd_pend,
   output logic [CRW-1:0]   cr_q
);
   if (NFLD < 2 || (NFLD & (NFLD - 1)) != 0) begin : g_bad_nfld
      $error("brunit_cr: NFLD must be a power of two, at least 2");
   end

   logic [NFLD-1:0] busy;
   logic [FSEL-1:0] rd_fld;
   logic            wr_hit;

   for (genvar f = 0; f < NFLD; f++) begin : g_fld
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cr_q[f*FW +: FW] <= '0;
            busy[f]          <= 1'b0;
         end else begin
            if (wr_en && wr_fld == FSEL'(f))
               cr_q[f*FW +: FW] <= wr_data;
            if (claim_en && claim_fld == FSEL'(f))
               busy[f] <= 1'b1;
            else if (wr_en && wr_fld == FSEL'(f))
               busy[f] <= 1'b0;
         end
      end
   end

   assign rd_fld  = rd_idx[IDX_W-1:2];
   assign wr_hit  = wr_en && (wr_fld == rd_fld);
   assign rd_bit  = wr_hit ? wr_data[rd_idx[1:0]] : cr_q[rd_idx];
   assign rd_pend = busy[rd_fld] && !wr_hit;

   // R8
   cr_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      claim_en |=> busy[$past(claim_fld)]);
   // R8
   cr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cr_q[$past(wr_fld)*FW +: FW] == $past(wr_data)));
endmodule

// File: rtl/brunit_pend.sv
module brunit_pend #(
   parameter int unsigned AW    = 32,
   parameter int unsigned IDX_W = 5,
   localparam int unsigned FSEL = IDX_W - 2,
   localparam int unsigned FW   = brunit_pkg::FLD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic [IDX_W-1:0] cap_bit,
   input  brunit_pkg::pend_flags_t cap_flags,
   input  logic [AW-1:0]    cap_tgt,
   input  logic [AW-1:0]    cap_fall,
   input  logic             wr_en,
   input  logic [FSEL-1:0]  wr_fld,
   input  logic [FW-1:0]    wr_data,
   output logic             busy,
   output logic             mis,
   output logic [AW-1:0]    mis_addr
);
   logic [IDX_W-1:0]        p_bit;
   brunit_pkg::pend_flags_t p_fl;
   logic [AW-1:0]           p_tgt;
   logic [AW-1:0]           p_fall;
   logic                    hit;
   logic                    actual;

   assign hit    = busy && wr_en && (wr_fld == p_bit[IDX_W-1:2]);
   assign actual = p_fl.ctr_ok && (wr_data[p_bit[1:0]] == p_fl.sense);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         mis      <= 1'b0;
         mis_addr <= '0;
         p_bit    <= '0;
         p_fl     <= '0;
         p_tgt    <= '0;
         p_fall   <= '0;
      end else begin
         mis <= hit && (actual != p_fl.pred_tkn);
         if (hit) begin
            busy     <= 1'b0;
            mis_addr <= actual ? p_tgt : p_fall;
         end else if (cap_en) begin
            busy   <= 1'b1;
            p_bit  <= cap_bit;
            p_fl   <= cap_flags;
            p_tgt  <= cap_tgt;
            p_fall <= cap_fall;
         end
      end
   end

   // R11
   mis_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mis |=> !mis);
   // R9
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !wr_en) |=> busy);
   // R10
   mis_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mis |-> !busy);
endmodule

// File: rtl/brunit_top.sv
module brunit_top #(
   parameter int unsigned AW     = 32,
   parameter int unsigned DISP_W = 24,
   parameter int unsigned CW     = 32,
   parameter int unsigned NFLD   = 8,
   localparam int unsigned CRW   = NFLD * brunit_pkg::FLD_W,
   localparam int unsigned FSEL  = $clog2(NFLD),
   localparam int unsigned IDX_W = $clog2(CRW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              br_valid,
   input  logic              br_kill,
   input  logic [AW-1:0]     br_pc,
   input  logic [DISP_W-1:0] br_disp,
   input  logic              br_to_link,
   input  logic              br_use_cond,
   input  logic [IDX_W-1:0]  br_bit,
   input  logic              br_sense,
   input  logic              br_use_ctr,
   input  logic              br_link,
   input  logic              br_hint,
   input  logic              ctr_ld_en,
   input  logic [CW-1:0]     ctr_ld_val,
   input  logic              cr_claim_en,
   input  logic [FSEL-1:0]   cr_claim_fld,
   input  logic              cr_wr_en,
   input  logic [FSEL-1:0]   cr_wr_fld,
   input  logic [brunit_pkg::FLD_W-1:0] cr_wr_data,
   output logic              br_ready,
   output logic              redir_valid,
   output logic [AW-1:0]     redir_addr,
   output logic              alt_hold,
   output logic              mispred,
   output logic [AW-1:0]     mispred_addr,
   output logic [AW-1:0]     lr_q,
   output logic [CW-1:0]     ctr_q,
   output logic [CRW-1:0]    cr_q
);
   logic [AW-1:0] rel_tgt, ret_addr, tgt;
   logic          acc, dec_nz, rd_bit, rd_pend;
   logic          ctr_ok, cond_ok, waits, taken, busy;
   brunit_pkg::pend_flags_t flags;

   brunit_tgt #(.AW(AW), .DISP_W(DISP_W)) u_tgt (
      .pc(br_pc), .disp(br_disp), .rel_tgt(rel_tgt), .ret_addr(ret_addr));

   brunit_ctr #(.CW(CW)) u_ctr (
      .clk(clk), .rst_n(rst_n), .ld_en(ctr_ld_en), .ld_val(ctr_ld_val),
      .dec_en(acc && br_use_ctr), .ctr_q(ctr_q), .dec_nz(dec_nz));

   brunit_cr #(.NFLD(NFLD)) u_cr (
      .clk(clk), .rst_n(rst_n), .claim_en(cr_claim_en),
      .claim_fld(cr_claim_fld), .wr_en(cr_wr_en), .wr_fld(cr_wr_fld),
      .wr_data(cr_wr_data), .rd_idx(br_bit), .rd_bit(rd_bit),
      .rd_pend(rd_pend), .cr_q(cr_q));

   always_comb begin
      acc     = br_valid && br_ready && !br_kill;
      tgt     = br_to_link ? lr_q : rel_tgt;
      ctr_ok  = !br_use_ctr || dec_nz;
      cond_ok = !br_use_cond || (rd_bit == br_sense);
      waits   = br_use_cond && rd_pend;
      taken   = waits ? (ctr_ok && br_hint) : (ctr_ok && cond_ok);
      flags   = '{pred_tkn: ctr_ok && br_hint, ctr_ok: ctr_ok, sense: br_sense};
   end

   brunit_pend #(.AW(AW), .IDX_W(IDX_W)) u_pend (
      .clk(clk), .rst_n(rst_n), .cap_en(acc && waits), .cap_bit(br_bit),
      .cap_flags(flags), .cap_tgt(tgt), .cap_fall(ret_addr),
      .wr_en(cr_wr_en), .wr_fld(cr_wr_fld), .wr_data(cr_wr_data),
      .busy(busy), .mis(mispred), .mis_addr(mispred_addr));

   assign br_ready    = !busy;
   assign alt_hold    = busy;
   assign redir_valid = acc && taken;
   assign redir_addr  = tgt;

   always_ff @(posedge clk) begin
      if (!rst_n)                lr_q <= '0;
      else if (acc && br_link)   lr_q <= ret_addr;
   end

   // R9
   busy_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !br_ready |-> !redir_valid);
   // R5
   lr_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && br_ready && !br_kill && br_link) |=> (lr_q == $past(br_pc) + AW'(4)));
   // R6
   kill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_kill && !ctr_ld_en) |=> ($stable(lr_q) && $stable(ctr_q)));
endmodule

// File: tb/brunit_top_tb.sv
module brunit_top_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        br_valid, br_kill, br_to_link, br_use_cond, br_sense;
   logic        br_use_ctr, br_link, br_hint;
   logic [31:0] br_pc;
   logic [23:0] br_disp;
   logic [4:0]  br_bit;
   logic        ctr_ld_en, cr_claim_en, cr_wr_en;
   logic [31:0] ctr_ld_val;
   logic [2:0]  cr_claim_fld, cr_wr_fld;
   logic [3:0]  cr_wr_data;
   logic        br_ready, redir_valid, alt_hold, mispred;
   logic [31:0] redir_addr, mispred_addr, lr_q, ctr_q, cr_q;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   brunit_top u_dut (.*);

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic clr();
      br_valid = 0; br_kill = 0; br_to_link = 0; br_use_cond = 0;
      br_sense = 0; br_use_ctr = 0; br_link = 0; br_hint = 0;
      br_pc = '0; br_disp = '0; br_bit = '0;
      ctr_ld_en = 0; ctr_ld_val = '0; cr_claim_en = 0; cr_claim_fld = '0;
      cr_wr_en = 0; cr_wr_fld = '0; cr_wr_data = '0;
   endtask

   task automatic br(logic [31:0] pc, logic [23:0] disp);
      br_valid = 1; br_pc = pc; br_disp = disp;
   endtask

   task automatic t_reset();
      chk("R1 ready", br_ready, 1);
      chk("R1 lr", lr_q, 0);
      chk("R1 ctr", ctr_q, 0);
      chk("R1 cr", cr_q, 0);
      chk("R1 hold/mis/redir", {alt_hold, mispred, redir_valid}, 0);
   endtask

   task automatic t_target();
      clr(); br(32'h1000, 24'd5); #1;
      chk("R2 fwd valid", redir_valid, 1);
      chk("R2 fwd addr", redir_addr, 32'h1014);
      tick(); clr(); br(32'h2000, -24'sd3); #1;
      chk("R2 back addr", {redir_valid, redir_addr}, {1'b1, 32'h1FF4});
      tick(); clr();
   endtask

   task automatic t_link();
      clr(); br(32'h3000, 24'd2); br_link = 1; tick();
      chk("R5 lr save", lr_q, 32'h3004);
      clr(); br(32'h5000, 24'd9); br_to_link = 1; br_link = 1; #1;
      chk("R5 old lr target", {redir_valid, redir_addr}, {1'b1, 32'h3004});
      tick();
      chk("R5 lr new", lr_q, 32'h5004);
      clr();
   endtask

   task automatic t_ctr();
      clr(); ctr_ld_en = 1; ctr_ld_val = 3; tick();
      chk("R7 load", ctr_q, 3);
      clr(); br(32'h100, -24'sd1); br_use_ctr = 1; #1;
      chk("R4 iter1 taken", redir_valid, 1); tick();
      chk("R4 ctr 2", ctr_q, 2); #1;
      chk("R4 iter2 taken", redir_valid, 1); tick();
      chk("R4 ctr 1", ctr_q, 1); #1;
      chk("R4 exit not taken", redir_valid, 0); tick();
      chk("R4 ctr 0", ctr_q, 0);
      ctr_ld_en = 1; ctr_ld_val = 7; tick();
      chk("R7 load beats dec", ctr_q, 7);
      clr();
   endtask

   task automatic t_cond();
      clr(); cr_wr_en = 1; cr_wr_fld = 2; cr_wr_data = 4'b0100; tick();
      chk("R8 field write", cr_q, 32'h0000_0400);
      clr(); br(32'h800, 24'd4); br_use_cond = 1; br_bit = 10; br_sense = 1; #1;
      chk("R3 bit set taken", redir_valid, 1);
      br_sense = 0; #1;
      chk("R3 sense clear not taken", redir_valid, 0);
      br_bit = 11; #1;
      chk("R3 neighbour bit taken", redir_valid, 1);
      br_sense = 1; #1;
      chk("R3 neighbour bit not taken", redir_valid, 0);
      clr(); ctr_ld_en = 1; ctr_ld_val = 5; tick();
      clr(); br(32'h900, 24'd1); br_use_ctr = 1; br_use_cond = 1; br_bit = 10; br_sense = 1; #1;
      chk("R4 ctr and cond taken", redir_valid, 1);
      br_sense = 0; #1;
      chk("R4 cond fails not taken", redir_valid, 0);
      tick();
      chk("R4 ctr dec on not taken", ctr_q, 4);
      clr();
   endtask

   task automatic t_kill();
      clr(); br(32'h7000, 24'd3); br_kill = 1; br_link = 1; br_use_ctr = 1; #1;
      chk("R6 no redirect", redir_valid, 0); tick();
      chk("R6 lr kept", lr_q, 32'h5004);
      chk("R6 ctr kept", ctr_q, 4);
      clr();
   endtask

   task automatic t_fwd();
      clr(); cr_claim_en = 1; cr_claim_fld = 3; tick();
      clr(); br(32'hA00, 24'd2); br_use_cond = 1; br_bit = 12; br_sense = 1;
      cr_wr_en = 1; cr_wr_fld = 3; cr_wr_data = 4'b0001; #1;
      chk("R8 forwarded taken", {redir_valid, redir_addr}, {1'b1, 32'hA08});
      tick();
      chk("R8 no pending", {alt_hold, br_ready}, 2'b01);
      clr();
   endtask

   task automatic t_pred_ok();
      clr(); cr_claim_en = 1; cr_claim_fld = 1; tick();
      clr(); br(32'h4000, 24'd4); br_use_cond = 1; br_bit = 4; br_sense = 1; br_hint = 1; #1;
      chk("R9 predicted redirect", {redir_valid, redir_addr}, {1'b1, 32'h4010});
      tick();
      chk("R9 hold", {br_ready, alt_hold}, 2'b01);
      clr(); br(32'h4444, 24'd1); br_link = 1; #1;
      chk("R9 ignored redirect", redir_valid, 0);
      tick();
      chk("R9 ignored lr", lr_q, 32'h5004);
      clr(); cr_wr_en = 1; cr_wr_fld = 1; cr_wr_data = 4'b0001; tick();
      chk("R10 correct no pulse", {mispred, alt_hold, br_ready}, 3'b001);
      clr();
   endtask

   task automatic t_pred_bad();
      clr(); cr_claim_en = 1; cr_claim_fld = 1; tick();
      clr(); br(32'h6000, 24'd8); br_use_cond = 1; br_bit = 5; br_sense = 1; br_hint = 1; tick();
      clr(); cr_wr_en = 1; cr_wr_fld = 1; cr_wr_data = 4'b0000; tick();
      chk("R10 mispredict fall", {mispred, mispred_addr}, {1'b1, 32'h6004});
      chk("R10 hold released", alt_hold, 0);
      clr(); tick();
      chk("R11 pulse ends", mispred, 0);
      cr_claim_en = 1; cr_claim_fld = 0; tick();
      clr(); br(32'h6100, 24'd2); br_use_cond = 1; br_bit = 2; br_sense = 1; #1;
      chk("R9 hint0 no redirect", redir_valid, 0);
      tick();
      clr(); cr_wr_en = 1; cr_wr_fld = 0; cr_wr_data = 4'b0100; tick();
      chk("R10 mispredict target", {mispred, mispred_addr}, {1'b1, 32'h6108});
      clr(); tick();
      chk("R11 single cycle", mispred, 0);
   endtask

   initial begin
      clr();
      rst_n = 0;
      repeat (3) tick();
      rst_n = 1;
      tick();
      t_reset();
      t_target();
      t_link();
      t_ctr();
      t_cond();
      t_kill();
      t_fwd();
      t_pred_ok();
      t_pred_bad();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
      end
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
      end
      $finish;
   end
endmodule